// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder

This block turns a bank of active-low request lines into the binary number of the most important request that is currently pending. It is purely combinational. A line is asserted when it is driven to 0. The code it returns is active low as well: the outputs carry the bitwise complement of the winning line's number.

The block is built from eight-line slices. Each slice has an enable input, a found flag and a pass-on enable. The top level chains a parameterised number of slices into one wider encoder, with sixteen request lines by default. The highest-numbered slice takes the external enable. Every other slice is enabled only when all slices above it see no request. The low bits of the combined code come from the slice codes. The upper bits name the slice that found a request.

A caller uses the found flag to learn that the code is valid. It can feed the pass-on enable into a further encoder that serves less important requests.

Top module: `prio_enc_cascade`

## Requirements
- R1: While `en_in_n` is 1, every bit of `code_n`, `grp_n` and `en_out_n` is 1, whatever the request lines carry.
- R2: While `en_in_n` is 0 and at least one bit of `req_n` is 0, `code_n` equals the bitwise complement of the highest index i whose `req_n[i]` is 0. Line 15 (the top) gives all zeros and line 0 gives all ones.
- R3: While enabled, the level of any request line below the highest asserted one has no effect on `code_n`. With every line asserted, `code_n` is all zeros.
- R4: `grp_n` is 0 exactly when `en_in_n` is 0 and at least one bit of `req_n` is 0.
- R5: `en_out_n` is 0 exactly when `en_in_n` is 0 and every bit of `req_n` is 1.
- R6: While enabled with no request asserted, `code_n` is all ones and `grp_n` is 1.
- R7: For a winning line i, the upper bits `code_n[CODE_W-1:3]` are the complement of i/8 (the slice number). The low three bits `code_n[2:0]` are the complement of i mod 8.
- R8: `grp_n` and `en_out_n` are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_in_n | input | 1 | Active-low enable for the whole encoder |
| req_n | input | STAGES*8 | Active-low request lines; the highest index has the highest priority |
| code_n | output | 3+$clog2(STAGES) | Complemented index of the winning request |
| grp_n | output | 1 | Low when enabled and some request is asserted |
| en_out_n | output | 1 | Low when enabled and no request is asserted; drives a lower-priority encoder |

## Verification
The assertions check the enable gating, the found flag, the pass-on enable, the idle code and the exclusion between the two flags on every input change. Each of these can be stated from the port levels alone. The winning index, and the fact that lower lines do not affect it, are shown only by the bench. The bench walks every combination of the enable and all sixteen request lines and compares each result against a behavioural search from the top line down.

// File: rtl/pe_pkg.sv
// Package: shared constants for the priority encoder slices.
// Assumes every slice serves exactly LANES request lines.
package pe_pkg;
    localparam int LANES  = 8;
    localparam int LANE_W = $clog2(LANES);
endpackage

// File: rtl/pe_stage.sv
// Module: one eight-line active-low priority encoder slice.
// The highest asserted line wins, and the code is its complemented index.
// Assumes: purely combinational; en_n high forces every output high.
module pe_stage
    import pe_pkg::*;
(
    input  logic [LANES-1:0]  req_n,
    input  logic              en_n,
    output logic [LANE_W-1:0] code_n,
    output logic              grp_n,
    output logic              eo_n
);
    logic [LANE_W-1:0] idx;
    logic              hit;

    // Purpose: scan upward so that the highest asserted line overwrites lower ones.
    always_comb begin
        idx = '0;
        hit = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (!req_n[i]) begin
                idx = LANE_W'(i);
                hit = 1'b1;
            end
        end
    end

    // Purpose: apply enable gating and form the active-low outputs.
    always_comb begin
        code_n = en_n ? '1 : ~idx;
        grp_n  = en_n | ~hit;
        eo_n   = en_n | hit;
    end
endmodule

// File: rtl/pe_code_merge.sv
// Module: merges the low code bits of all slices by a bitwise AND.
// Assumes that idle or disabled slices present all ones, so at most one slice pulls bits low.
module pe_code_merge
    import pe_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic [STAGES*LANE_W-1:0] codes_n,
    output logic [LANE_W-1:0]        low_n
);
    // Purpose: AND the active-low codes of all slices.
    always_comb begin
        low_n = '1;
        for (int k = 0; k < STAGES; k++) begin
            low_n = low_n & codes_n[k*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/pe_group_select.sv
// Module: forms the upper code bits from the slice found flags.
// Assumes at most one found flag is low at a time, which the enable chain guarantees.
module pe_group_select #(
    parameter int STAGES = 2,
    localparam int SEL_W = $clog2(STAGES)
) (
    input  logic [STAGES-1:0] grp_n,
    output logic [SEL_W-1:0]  sel_n
);
    logic [SEL_W-1:0] sel;

    // Purpose: encode the number of the slice whose found flag is low, then complement it.
    always_comb begin
        sel = '0;
        for (int k = 0; k < STAGES; k++) begin
            if (!grp_n[k]) sel = sel | SEL_W'(k);
        end
        sel_n = ~sel;
    end
endmodule

// File: rtl/prio_enc_cascade.sv
// Module: a wide active-low priority encoder built by chaining eight-line slices.
// Slice STAGES-1 serves the top lines and takes the external enable.
// Each lower slice is enabled by the pass-on output of the slice above it.
// Assumes STAGES >= 2; the logic is purely combinational.
module prio_enc_cascade
    import pe_pkg::*;
#(
    parameter int STAGES = 2,
    localparam int SEL_W  = $clog2(STAGES),
    localparam int NREQ   = STAGES * LANES,
    localparam int CODE_W = LANE_W + SEL_W
) (
    input  logic              en_in_n,
    input  logic [NREQ-1:0]   req_n,
    output logic [CODE_W-1:0] code_n,
    output logic              grp_n,
    output logic              en_out_n
);
    logic [STAGES-1:0]        st_en_n;
    logic [STAGES-1:0]        st_eo_n;
    logic [STAGES-1:0]        st_grp_n;
    logic [STAGES*LANE_W-1:0] st_code_n;
    logic [LANE_W-1:0]        low_n;
    logic [SEL_W-1:0]         sel_n;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == STAGES - 1) begin : g_top
            assign st_en_n[k] = en_in_n;
        end else begin : g_chain
            assign st_en_n[k] = st_eo_n[k+1];
        end

        pe_stage u_stage (
            .req_n  (req_n[k*LANES +: LANES]),
            .en_n   (st_en_n[k]),
            .code_n (st_code_n[k*LANE_W +: LANE_W]),
            .grp_n  (st_grp_n[k]),
            .eo_n   (st_eo_n[k])
        );
    end

    pe_code_merge #(.STAGES(STAGES)) u_merge (
        .codes_n (st_code_n),
        .low_n   (low_n)
    );

    pe_group_select #(.STAGES(STAGES)) u_gsel (
        .grp_n (st_grp_n),
        .sel_n (sel_n)
    );

    // Purpose: assemble the combined outputs from the merged slice results.
    always_comb begin
        code_n   = {sel_n, low_n};
        grp_n    = &st_grp_n;
        en_out_n = st_eo_n[0];
    end
endmodule

// File: rtl/prio_enc_cascade_chk.sv
// Module: port-level checker for prio_enc_cascade, attached with bind.
// Assumes combinational outputs; the checks run whenever any observed port changes.
module prio_enc_cascade_chk #(
    parameter int STAGES = 2,
    localparam int NREQ   = STAGES * 8,
    localparam int CODE_W = 3 + $clog2(STAGES)
) (
    input logic              en_in_n,
    input logic [NREQ-1:0]   req_n,
    input logic [CODE_W-1:0] code_n,
    input logic              grp_n,
    input logic              en_out_n
);
    logic any_req;

    // Purpose: evaluate the port-level rules whenever any observed port changes.
    always_comb begin
        any_req = (req_n != '1);
        if (en_in_n) begin
            a_r1_disabled_high : assert (code_n == '1 && grp_n && en_out_n)
                else $error("R1 outputs not all high while disabled");
        end
        a_r4_grp_flag : assert (grp_n == !(!en_in_n && any_req))
            else $error("R4 grp_n mismatch");
        a_r5_pass_enable : assert (en_out_n == !(!en_in_n && !any_req))
            else $error("R5 en_out_n mismatch");
        if (!en_in_n && !any_req) begin
            a_r6_idle_code : assert (code_n == '1 && grp_n)
                else $error("R6 idle outputs wrong");
        end
        a_r8_flags_exclusive : assert (grp_n || en_out_n)
            else $error("R8 both flags low");
    end
endmodule

bind prio_enc_cascade prio_enc_cascade_chk #(.STAGES(STAGES)) u_chk (
    .en_in_n  (en_in_n),
    .req_n    (req_n),
    .code_n   (code_n),
    .grp_n    (grp_n),
    .en_out_n (en_out_n)
);

// File: tb/prio_enc_cascade_bench.sv
// Bench: exhaustive comparison of prio_enc_cascade against a behavioural search.
module prio_enc_cascade_bench;
    localparam int STAGES = 2;
    localparam int NREQ   = STAGES * 8;
    localparam int CODE_W = 3 + $clog2(STAGES);

    logic              clk = 1'b0;
    logic              en_in_n;
    logic [NREQ-1:0]   req_n;
    logic [CODE_W-1:0] code_n;
    logic              grp_n;
    logic              en_out_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    prio_enc_cascade #(.STAGES(STAGES)) u_prio_enc_cascade (
        .en_in_n  (en_in_n),
        .req_n    (req_n),
        .code_n   (code_n),
        .grp_n    (grp_n),
        .en_out_n (en_out_n)
    );

    // Reference: search from the top line down for the first asserted one.
    function automatic int top_req(input logic [NREQ-1:0] r);
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (r[i] == 1'b0) return i;
        end
        return -1;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (en_in_n=%b req_n=%h)",
                     tag, act, exp, en_in_n, req_n);
        end
    endtask

    task automatic apply_and_compare(input logic en, input logic [NREQ-1:0] r);
        int w;
        int exp_code;
        @(posedge clk);
        en_in_n = en;
        req_n   = r;
        @(negedge clk);
        w = top_req(r);
        if (en) begin
            check("R1 code", int'(code_n), (1 << CODE_W) - 1);
            check("R1 grp", int'(grp_n), 1);
            check("R1 eo", int'(en_out_n), 1);
        end else if (w < 0) begin
            check("R6 code", int'(code_n), (1 << CODE_W) - 1);
            check("R6 grp", int'(grp_n), 1);
            check("R5 eo", int'(en_out_n), 0);
        end else begin
            exp_code = (~w) & ((1 << CODE_W) - 1);
            check("R2 code", int'(code_n), exp_code);
            check("R7 upper", int'(code_n[CODE_W-1:3]), (~(w / 8)) & ((1 << (CODE_W - 3)) - 1));
            check("R7 lower", int'(code_n[2:0]), (~(w % 8)) & 7);
            check("R4 grp", int'(grp_n), 0);
            check("R5 eo", int'(en_out_n), 1);
        end
        check("R8 exclusive", int'(grp_n | en_out_n), 1);
    endtask

    initial begin
        en_in_n = 1'b1;
        req_n   = '1;
        // Initial state: disabled and idle, all outputs high (R1).
        apply_and_compare(1'b1, '1);
        // R3: all lines asserted, so the top line wins and the code is all zeros.
        apply_and_compare(1'b0, '0);
        check("R3 all asserted", int'(code_n), 0);
        // R3: top line asserted, lower lines toggled, code unchanged.
        apply_and_compare(1'b0, 16'h7FFF);
        check("R3 top only", int'(code_n), 0);
        apply_and_compare(1'b0, 16'h5A3C);
        check("R3 lower noise", int'(code_n), 0);
        // R2: only line 0 asserted gives all ones.
        apply_and_compare(1'b0, 16'hFFFE);
        check("R2 line0", int'(code_n), 15);
        // Exhaustive sweep over enable and every request pattern.
        for (int v = 0; v < (1 << (NREQ + 1)); v++) begin
            apply_and_compare(v[NREQ], v[NREQ-1:0]);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule